// File: doc/BRIEF.md
# Configuration register bank with per-field access policies

This block is a compact memory-mapped register bank for chip configuration. Software reaches it through a single-cycle request port carrying a byte address, write data and byte enables. Every request, whether it hits a defined register or a reserved hole, is acknowledged exactly one cycle later. For a read, that acknowledgement carries the read data.

Each field in the bank has its own access policy:

- plain read/write, with a reset default taken from strap inputs
- self-clearing, where hardware drops the field back to zero
- lockable self-clearing, which a write-once lock bit can freeze
- write-1-to-clear status, which hardware events set
- write-once, which takes the first write after reset and then turns read-only
- write-only command, which produces a one-cycle strobe and reads as zero

Word addresses 4 and above, and any address with nonzero low two bits, are reserved. They read as zero and ignore writes. A synchronous reset reloads every field. Two fields take their defaults from strap pins sampled during reset.

Top module: `cfg_regbank`

## Requirements
- R1: While `rst` is high, all of the following hold. `cfg_o` loads `strap_cfg_i` and `once_o` loads `strap_once_i`. `go_o`, `lgo_o`, `lock_o`, `status_o`, `cmd_stb_o` and `ack_o` are 0. The write-once fields are re-armed.
- R2: A request in one cycle raises `ack_o` in the next cycle, and only then. `rdata_o` is zero on a write acknowledgement. Reserved locations are word index 4 and up, or any address with `addr_i[1:0]` nonzero. A read of a reserved location returns zero, and a write to one changes no field.
- R3: Word 0 bits [15:0] form `cfg_o`, which is plain read/write. Byte enable 0 gates bits [7:0] and byte enable 1 gates bits [15:8]. Word 0 bits [23:18] and [31:25] read as zero.
- R4: Word 0 bit 16 is `go_o`. A write with byte enable 2 loads bit 16 into it. `sc_clr_i[0]` clears it in the next cycle. When a write and the clear arrive in the same cycle, the written value wins.
- R5: Word 0 bit 17 is `lgo_o`. It behaves like `go_o`, but uses `sc_clr_i[1]` as its clear. While `lock_o` is 1, software writes to it are ignored.
- R6: Word 0 bit 24 is `lock_o`, a write-once field. The first write with byte enable 3 set loads it. Every later write is ignored until reset.
- R7: Word 1 bits [7:0] are `status_o`, and every other bit of word 1 reads as zero. Writing 1 to a bit clears it and writing 0 leaves it unchanged. `hw_set_i[k]` sets bit k in the next cycle. When a set and a clear hit the same bit together, the set wins.
- R8: Word 2 is `once_o`. The first write after reset that has any byte enable set loads the enabled bytes. All later writes are ignored until reset.
- R9: Word 3 is write-only and reads as zero. A write to it with byte enable 0 set pulses `cmd_stb_o` for one cycle, aligned with `ack_o`, and sets `cmd_o` to wdata[7:0]. A write without byte enable 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| rdata_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | Completion strobe |
| strap_cfg_i | input | 16 | Reset default for cfg_o |
| strap_once_i | input | 32 | Reset default for once_o |
| hw_set_i | input | 8 | Hardware set events for status bits |
| sc_clr_i | input | 2 | Hardware clear for go_o (bit 0) and lgo_o (bit 1) |
| cfg_o | output | 16 | Read/write configuration field |
| go_o | output | 1 | Self-clearing control bit |
| lgo_o | output | 1 | Lockable self-clearing control bit |
| lock_o | output | 1 | Lock bit |
| status_o | output | 8 | Write-1-to-clear status |
| once_o | output | 32 | Write-once field |
| cmd_o | output | 8 | Last command byte written |
| cmd_stb_o | output | 1 | Command strobe |

## Verification
The hardest situations to reach from the ports are same-cycle collisions. One is a hardware set landing on a status bit in the very cycle software clears it. Another is a hardware self-clear racing a software write of 1. The bench drives these inputs in the same task call that issues the request, so both act on one clock edge. Write-once behaviour depends on history, and a lock consumed too early would hide the lockable field. The bench therefore orders its byte-enable sweep to avoid byte lane 3 on word 0. It then re-enters reset between the lock, write-once and command phases, and checks that straps and re-arming come back.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    localparam int BUS_W    = 32;
    localparam int BE_W     = BUS_W / 8;
    localparam int CFG_W    = 16;
    localparam int ST_W     = 8;
    localparam int CMD_W    = 8;
    localparam int GO_BIT   = 16;
    localparam int LGO_BIT  = 17;
    localparam int LOCK_BIT = 24;

    typedef enum logic [2:0] {
        RG_CTRL,
        RG_STAT,
        RG_ONCE,
        RG_CMD,
        RG_RSV
    } rg_sel_e;

    function automatic logic [BUS_W-1:0] be_mask(input logic [BE_W-1:0] be);
        logic [BUS_W-1:0] m;
        for (int b = 0; b < BE_W; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
    import cfg_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output rg_sel_e           sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    assign widx = addr[ADDR_W-1:2];

    always_comb begin
        if (addr[1:0] != 2'b00)               sel = RG_RSV;
        else if (widx == IDX_W'(0))           sel = RG_CTRL;
        else if (widx == IDX_W'(1))           sel = RG_STAT;
        else if (widx == IDX_W'(2))           sel = RG_ONCE;
        else if (widx == IDX_W'(3))           sel = RG_CMD;
        else                                  sel = RG_RSV;
    end
endmodule

// File: rtl/cfg_w1c_bits.sv
module cfg_w1c_bits #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                        q[k] <= 1'b0;
            else if (hw_set[k])             q[k] <= 1'b1;
            else if (wr_en && wdata[k])     q[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_once_reg.sv
module cfg_once_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dflt,
    input  logic         wr_en,
    input  logic [W-1:0] wmask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= dflt;
            armed <= 1'b1;
        end else if (wr_en && armed) begin
            q     <= (q & ~wmask) | (wdata & wmask);
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_i,
    output logic [31:0]       rdata_o,
    output logic              ack_o,
    input  logic [15:0]       strap_cfg_i,
    input  logic [31:0]       strap_once_i,
    input  logic [7:0]        hw_set_i,
    input  logic [1:0]        sc_clr_i,
    output logic [15:0]       cfg_o,
    output logic              go_o,
    output logic              lgo_o,
    output logic              lock_o,
    output logic [7:0]        status_o,
    output logic [31:0]       once_o,
    output logic [7:0]        cmd_o,
    output logic              cmd_stb_o
);
    localparam int CFG_BYTES = CFG_W / 8;

    rg_sel_e    sel;
    logic       wr, rd;
    logic       ctrl_wr, stat_wr, once_wr, cmd_wr;
    logic [BUS_W-1:0] rd_word;

    cfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr_i),
        .sel  (sel)
    );

    assign wr      = req_i && we_i;
    assign rd      = req_i && !we_i;
    assign ctrl_wr = wr && (sel == RG_CTRL);
    assign stat_wr = wr && (sel == RG_STAT) && be_i[0];
    assign once_wr = wr && (sel == RG_ONCE) && (|be_i);
    assign cmd_wr  = wr && (sel == RG_CMD)  && be_i[0];

    // plain read/write field, byte-gated
    for (genvar b = 0; b < CFG_BYTES; b++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)                      cfg_o[8*b +: 8] <= strap_cfg_i[8*b +: 8];
            else if (ctrl_wr && be_i[b])  cfg_o[8*b +: 8] <= wdata_i[8*b +: 8];
        end
    end

    // self-clearing bits; a software write takes precedence over a hardware clear
    always_ff @(posedge clk) begin
        if (rst) begin
            go_o  <= 1'b0;
            lgo_o <= 1'b0;
        end else begin
            if (ctrl_wr && be_i[GO_BIT/8])                 go_o <= wdata_i[GO_BIT];
            else if (sc_clr_i[0])                          go_o <= 1'b0;
            if (ctrl_wr && be_i[LGO_BIT/8] && !lock_o)     lgo_o <= wdata_i[LGO_BIT];
            else if (sc_clr_i[1])                          lgo_o <= 1'b0;
        end
    end

    cfg_once_reg #(.W(1)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .dflt  (1'b0),
        .wr_en (ctrl_wr && be_i[LOCK_BIT/8]),
        .wmask (1'b1),
        .wdata (wdata_i[LOCK_BIT]),
        .q     (lock_o)
    );

    cfg_w1c_bits #(.W(ST_W)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (stat_wr),
        .wdata  (wdata_i[ST_W-1:0]),
        .hw_set (hw_set_i),
        .q      (status_o)
    );

    cfg_once_reg #(.W(BUS_W)) u_once (
        .clk   (clk),
        .rst   (rst),
        .dflt  (strap_once_i),
        .wr_en (once_wr),
        .wmask (be_mask(be_i)),
        .wdata (wdata_i),
        .q     (once_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o     <= '0;
            cmd_stb_o <= 1'b0;
        end else begin
            cmd_stb_o <= cmd_wr;
            if (cmd_wr) cmd_o <= wdata_i[CMD_W-1:0];
        end
    end

    always_comb begin
        rd_word = '0;
        case (sel)
            RG_CTRL: begin
                rd_word[CFG_W-1:0] = cfg_o;
                rd_word[GO_BIT]    = go_o;
                rd_word[LGO_BIT]   = lgo_o;
                rd_word[LOCK_BIT]  = lock_o;
            end
            RG_STAT: rd_word[ST_W-1:0] = status_o;
            RG_ONCE: rd_word = once_o;
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_o   <= req_i;
            rdata_o <= rd ? rd_word : '0;
        end
    end
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        hw_set_i,
    input logic [31:0]       rdata_o,
    input logic              ack_o,
    input logic              lock_o,
    input logic              lgo_o,
    input logic [7:0]        status_o,
    input logic              cmd_stb_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic rsv_rd;
    assign rsv_rd = req_i && !we_i &&
                    ((addr_i[ADDR_W-1:2] >= IDX_W'(4)) || (addr_i[1:0] != 2'b00));

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        req_i |=> ack_o);
    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !ack_o);
    assert_reserved_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rsv_rd |=> (rdata_o == 32'h0));
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> lock_o);
    assert_locked_lgo_stays_low_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_o && !lgo_o) |=> !lgo_o);
    assert_hw_set_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (|hw_set_i) |=> ((status_o & $past(hw_set_i)) == $past(hw_set_i)));
    assert_strobe_from_write_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_stb_o |-> $past(req_i && we_i));
endmodule

bind cfg_regbank cfg_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .hw_set_i  (hw_set_i),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o),
    .lock_o    (lock_o),
    .lgo_o     (lgo_o),
    .status_o  (status_o),
    .cmd_stb_o (cmd_stb_o)
);

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
    localparam int AW = 6;
    localparam logic [15:0] S_CFG  = 16'hA5C3;
    localparam logic [31:0] S_ONCE = 32'h1234_5678;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0, we_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  be_i = '0;
    logic [31:0] rdata_o;
    logic ack_o;
    logic [7:0] hw_set_i = '0;
    logic [1:0] sc_clr_i = '0;
    logic [15:0] cfg_o;
    logic go_o, lgo_o, lock_o, cmd_stb_o;
    logic [7:0] status_o, cmd_o;
    logic [31:0] once_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model of the registers
    logic [15:0] m_cfg;
    logic m_go, m_lgo, m_lock;
    logic [7:0] m_st;
    logic [31:0] m_once;

    always #2.5 clk = ~clk;

    cfg_regbank #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o), .ack_o(ack_o),
        .strap_cfg_i(S_CFG), .strap_once_i(S_ONCE), .hw_set_i(hw_set_i),
        .sc_clr_i(sc_clr_i), .cfg_o(cfg_o), .go_o(go_o), .lgo_o(lgo_o),
        .lock_o(lock_o), .status_o(status_o), .once_o(once_o), .cmd_o(cmd_o),
        .cmd_stb_o(cmd_stb_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int idx);
        case (idx)
            0: return {7'b0, m_lock, 6'b0, m_lgo, m_go, m_cfg};
            1: return {24'b0, m_st};
            2: return m_once;
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_cfg = S_CFG; m_go = 0; m_lgo = 0; m_lock = 0; m_st = 0; m_once = S_ONCE;
    endtask

    task automatic acc(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [7:0] hs, input logic [1:0] sc,
                       output logic [31:0] rd);
        @(negedge clk);
        req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
        hw_set_i = hs; sc_clr_i = sc;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0; hw_set_i = '0; sc_clr_i = '0;
        chk("R2 ack", {31'b0, ack_o}, 32'h1);
        rd = rdata_o;
    endtask

    task automatic verify_all(input string tag);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            acc(1'b0, AW'(4*i), 32'h0, 4'h0, 8'h0, 2'b0, r);
            chk(tag, r, exp_word(i));
        end
        chk(tag, {16'b0, cfg_o}, {16'b0, m_cfg});
        chk(tag, {24'b0, status_o}, {24'b0, m_st});
        chk(tag, once_o, m_once);
        chk(tag, {29'b0, lock_o, lgo_o, go_o}, {29'b0, m_lock, m_lgo, m_go});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1: reset state at the ports
        chk("R1 outputs", {cfg_o, 8'b0, status_o}, {S_CFG, 16'b0});
        chk("R1 once", once_o, S_ONCE);
        chk("R1 bits", {27'b0, go_o, lgo_o, lock_o, cmd_stb_o, ack_o}, 32'h0);

        // R1/R2: read sweep over every word and misaligned reserved reads
        for (int i = 0; i < 16; i++) begin
            acc(1'b0, AW'(4*i), 32'h0, 4'h0, 8'h0, 2'b0, r);
            chk("R1 R2 read sweep", r, exp_word(i));
        end
        for (int o = 1; o < 4; o++) begin
            acc(1'b0, AW'(o), 32'h0, 4'h0, 8'h0, 2'b0, r);
            chk("R2 misaligned read", r, 32'h0);
        end

        // R2: writes to reserved locations change nothing; write ack has zero data
        for (int i = 4; i < 16; i++) begin
            acc(1'b1, AW'(4*i), 32'hFFFF_FFFF, 4'hF, 8'h0, 2'b0, r);
            chk("R2 write ack data", r, 32'h0);
        end
        acc(1'b1, AW'(1), 32'hFFFF_FFFF, 4'hF, 8'h0, 2'b0, r);
        acc(1'b1, AW'(10), 32'hFFFF_FFFF, 4'hF, 8'h0, 2'b0, r);
        verify_all("R2 reserved write ignored");

        // R3/R4/R5: byte-enable sweep on word 0 lanes 0..2 (lock lane untouched)
        for (int be = 0; be < 8; be++) begin
            logic [31:0] d;
            d = {8'hFF, 6'h3F, be[0], ~be[0], 8'h11 * be[7:0] + 8'h3C, 8'h5A ^ be[7:0]};
            acc(1'b1, AW'(0), d, be[3:0], 8'h0, 2'b0, r);
            if (be[0]) m_cfg[7:0]  = d[7:0];
            if (be[1]) m_cfg[15:8] = d[15:8];
            if (be[2]) begin m_go = d[16]; m_lgo = d[17]; end
            verify_all("R3 R4 R5 byte lanes");
        end
        // R4/R5: hardware self-clear
        acc(1'b1, AW'(0), 32'h0003_0000, 4'h4, 8'h0, 2'b0, r);
        m_go = 1; m_lgo = 1;
        chk("R4 R5 set", {30'b0, lgo_o, go_o}, 32'h3);
        acc(1'b0, AW'(60), 32'h0, 4'h0, 8'h0, 2'b01, r);
        m_go = 0;
        chk("R4 hw clear", {30'b0, lgo_o, go_o}, 32'h2);
        acc(1'b0, AW'(60), 32'h0, 4'h0, 8'h0, 2'b10, r);
        m_lgo = 0;
        chk("R5 hw clear", {30'b0, lgo_o, go_o}, 32'h0);
        // R4: write of 1 and hardware clear in the same cycle: write wins
        acc(1'b1, AW'(0), 32'h0001_0000, 4'h4, 8'h0, 2'b01, r);
        m_go = 1;
        chk("R4 collision", {31'b0, go_o}, 32'h1);

        // R6/R5: lock freezes lgo
        acc(1'b1, AW'(0), 32'h0100_0000, 4'h8, 8'h0, 2'b0, r);
        m_lock = 1;
        chk("R6 lock set", {31'b0, lock_o}, 32'h1);
        acc(1'b1, AW'(0), 32'h0003_0000, 4'h4, 8'h0, 2'b0, r);
        chk("R5 locked write ignored", {30'b0, lgo_o, go_o}, 32'h1);
        acc(1'b1, AW'(0), 32'h0000_0000, 4'h8, 8'h0, 2'b0, r);
        verify_all("R6 second lock write ignored");
        // R6: a first write of 0 consumes the lock
        do_reset();
        chk("R1 R6 lock after reset", {31'b0, lock_o}, 32'h0);
        acc(1'b1, AW'(0), 32'h0000_0000, 4'h8, 8'h0, 2'b0, r);
        acc(1'b1, AW'(0), 32'h0100_0000, 4'h8, 8'h0, 2'b0, r);
        chk("R6 write once of zero", {31'b0, lock_o}, 32'h0);
        acc(1'b1, AW'(0), 32'h0002_0000, 4'h4, 8'h0, 2'b0, r);
        m_lgo = 1;
        chk("R5 unlocked write", {31'b0, lgo_o}, 32'h1);

        // R7: status sweep
        acc(1'b0, AW'(60), 32'h0, 4'h0, 8'hFF, 2'b0, r);
        m_st = 8'hFF;
        chk("R7 hw set all", {24'b0, status_o}, 32'hFF);
        acc(1'b1, AW'(4), 32'hFFFF_FF00, 4'hF, 8'h0, 2'b0, r);
        chk("R7 write zero no effect", {24'b0, status_o}, 32'hFF);
        for (int k = 0; k < 8; k++) begin
            acc(1'b1, AW'(4), 32'(1 << k), 4'h1, 8'h0, 2'b0, r);
            m_st[k] = 1'b0;
            acc(1'b0, AW'(4), 32'h0, 4'h0, 8'h0, 2'b0, r);
            chk("R7 w1c bit", r, {24'b0, m_st});
        end
        for (int k = 0; k < 8; k++) begin
            acc(1'b1, AW'(4), 32'hFF, 4'h1, 8'(1 << k), 2'b0, r);
            m_st = 8'(1 << k);
            chk("R7 set beats clear", {24'b0, status_o}, {24'b0, m_st});
        end

        // R8: write-once word
        acc(1'b1, AW'(8), 32'hFFFF_0000, 4'h3, 8'h0, 2'b0, r);
        m_once = 32'h1234_0000;
        chk("R8 first write", once_o, m_once);
        acc(1'b1, AW'(8), 32'hDEAD_BEEF, 4'hF, 8'h0, 2'b0, r);
        verify_all("R8 later write ignored");
        do_reset();
        chk("R8 R1 re-armed", once_o, S_ONCE);
        acc(1'b1, AW'(8), 32'hDEAD_BEEF, 4'hC, 8'h0, 2'b0, r);
        chk("R8 second life", once_o, 32'hDEAD_5678);
        m_once = 32'hDEAD_5678;

        // R9: write-only command
        acc(1'b1, AW'(12), 32'h0000_005A, 4'h1, 8'h0, 2'b0, r);
        chk("R9 strobe", {23'b0, cmd_stb_o, cmd_o}, {23'b0, 1'b1, 8'h5A});
        @(negedge clk);
        chk("R9 strobe one cycle", {31'b0, cmd_stb_o}, 32'h0);
        acc(1'b1, AW'(12), 32'h0000_00C3, 4'h2, 8'h0, 2'b0, r);
        chk("R9 no lane0 no strobe", {23'b0, cmd_stb_o, cmd_o}, {23'b0, 1'b0, 8'h5A});
        acc(1'b0, AW'(12), 32'h0, 4'h0, 8'h0, 2'b0, r);
        chk("R9 reads zero", r, 32'h0);
        verify_all("R9 no side effect");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule